// File: doc/BRIEF.md
# Pipelined Burst SRAM Control Front-End

This block is the synchronous control side of a pipelined burst SRAM. Its storage array is modelled behaviourally inside the block. Each word is 18 bits wide and is split into two 9-bit lanes. The lower lane is bits 8:0 and the upper lane is bits 17:9. The address width is a parameter and defaults to a small array.

There are two active-low address strobes. One belongs to a processor and one to a memory controller. Either strobe starts an access when three chip enables select the part, and it deselects the part when they do not. The processor strobe has priority over the controller strobe. The processor strobe is disregarded outright whenever the first enable is high. The low two address bits are loaded into a burst counter, which steps linearly modulo 4 whenever the advance input is low on a continuing clock. The upper address bits stay fixed for the whole burst.

On every clock after the start edge, an active access does one of two things. It writes if the write inputs request it, and otherwise it reads. A global write stores both lanes. A lane write needs the lane-write enable and that lane's select. Read data leaves through one output register together with a valid flag. A drive-enable output stands in for the pad output enable: it follows an asynchronous active-low enable input, and it is held off for the first read after the part has been deselected.

Top module: `burst_sram_ctl`

## Requirements
- R1: After reset, `rd_valid` and `rd_drive` are 0, and clocks without a strobe produce no read until an access is started.
- R2: A strobe edge where the enables do not all select the part (`sel_a_n`=0, `sel_b`=1, `sel_c_n`=0) ends any access, and no read follows it.
- R3: When both strobes are low and the processor strobe is accepted, the access is started as a processor access, so write inputs on that edge do not write.
- R4: The processor strobe is disregarded whenever `sel_a_n` is 1, so the current access continues at its old address. The controller strobe can still deselect in that case.
- R5: On each continuing clock with `burst_adv_n`=0, the low two address bits advance by +1 modulo 4 after that clock's access, while the upper bits stay fixed.
- R6: On a continuing clock with `burst_adv_n`=1 and no write, the same address is read again.
- R7: With `all_wr_n`=0, both lanes are written, whatever the values of `lane_wr_en_n` and `lane_sel_n`.
- R8: With `all_wr_n`=1, lane i (bit i of `lane_sel_n`; lane 0 is data bits 8:0, lane 1 is bits 17:9) is written only when `lane_wr_en_n`=0 and `lane_sel_n[i]`=0. Otherwise that clock reads.
- R9: A controller-started access writes on its start edge. A processor-started access takes its write data no earlier than the next clock.
- R10: A read done on a clock edge appears on `rd_data` with `rd_valid`=1 right after that edge. A start edge itself yields `rd_valid`=0.
- R11: `rd_drive` is 1 only while `rd_valid`=1 and `out_en_n`=0 (the latter taking effect without a clock). It stays 0 for the first read after a deselect or reset if no write has happened since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address sampled on a strobe |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low |
| burst_adv_n | input | 1 | Burst advance, active low |
| sel_a_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| sel_b | input | 1 | Chip enable, active high |
| sel_c_n | input | 1 | Chip enable, active low |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_sel_n | input | 2 | Per-lane write selects, active low |
| wdata | input | 18 | Write data, two 9-bit lanes |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| rd_data | output | 18 | Registered read data |
| rd_valid | output | 1 | `rd_data` holds a fresh read |
| rd_drive | output | 1 | Bus drive enable for read data |

## Verification
The assertions assume that every synchronous input is settled and free of X at each rising edge after reset. They also assume that `out_en_n` changes only between edges. The hold and masking properties further assume that no write request appears on the clocks they span. The bench changes every input 1 ns after an edge and samples at the falling edge. It only reads locations it has already written, so expected data is never undefined. Each sequence runs in lockstep with the clock, so every read the design makes has an expected entry queued for it.

// File: rtl/sbfe_pkg.sv
package sbfe_pkg;
    localparam int CNT_W  = 2;
    localparam int LANES  = 2;
    localparam int LANE_W = 9;
    localparam int WORD_W = LANES * LANE_W;

    typedef struct packed {
        logic cpu_go;
        logic ctl_go;
        logic selected;
    } strobe_t;
endpackage

// File: rtl/sbfe_decode.sv
module sbfe_decode
    import sbfe_pkg::*;
(
    input  logic             cpu_strobe_n,
    input  logic             ctl_strobe_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             all_wr_n,
    input  logic             lane_wr_en_n,
    input  logic [LANES-1:0] lane_sel_n,
    output strobe_t          cmd,
    output logic [LANES-1:0] wr_lanes
);
    // Processor strobe only counts with the first enable low; it then wins.
    always_comb begin
        cmd.cpu_go   = !cpu_strobe_n && !sel_a_n;
        cmd.ctl_go   = !ctl_strobe_n && !cmd.cpu_go;
        cmd.selected = !sel_a_n && sel_b && !sel_c_n;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign wr_lanes[g] = !all_wr_n || (!lane_wr_en_n && !lane_sel_n[g]);
    end
endmodule

// File: rtl/sbfe_array.sv
module sbfe_array
    import sbfe_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic [LANES-1:0]  we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rword
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rword[g*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
    import sbfe_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cpu_strobe_n,
    input  logic              ctl_strobe_n,
    input  logic              burst_adv_n,
    input  logic              sel_a_n,
    input  logic              sel_b,
    input  logic              sel_c_n,
    input  logic              all_wr_n,
    input  logic              lane_wr_en_n,
    input  logic [LANES-1:0]  lane_sel_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic              out_en_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_drive
);
    localparam int HI_W = ADDR_W - CNT_W;

    typedef struct packed {
        logic [HI_W-1:0]   hi;
        logic [CNT_W-1:0]  cnt;
        logic              active;
        logic              fresh;   // no access since deselect/reset
        logic              rvalid;
        logic              mask;
        logic [WORD_W-1:0] rdata;
    } st_t;

    localparam st_t ST_RST = '{
        hi: '0, cnt: '0, active: 1'b0, fresh: 1'b1,
        rvalid: 1'b0, mask: 1'b0, rdata: '0
    };

    st_t               st_q, st_d;
    strobe_t           cmd;
    logic [LANES-1:0]  wr_lanes;
    logic [LANES-1:0]  mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [ADDR_W-1:0] acc_addr;
    logic [WORD_W-1:0] mem_rword;

    sbfe_decode u_decode (
        .cpu_strobe_n (cpu_strobe_n),
        .ctl_strobe_n (ctl_strobe_n),
        .sel_a_n      (sel_a_n),
        .sel_b        (sel_b),
        .sel_c_n      (sel_c_n),
        .all_wr_n     (all_wr_n),
        .lane_wr_en_n (lane_wr_en_n),
        .lane_sel_n   (lane_sel_n),
        .cmd          (cmd),
        .wr_lanes     (wr_lanes)
    );

    sbfe_array #(.ADDR_W(ADDR_W)) u_array (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (wdata),
        .raddr (acc_addr),
        .rword (mem_rword)
    );

    assign acc_addr = {st_q.hi, st_q.cnt};

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.mask   = 1'b0;
        mem_we      = '0;
        mem_waddr   = acc_addr;
        if (cmd.cpu_go || cmd.ctl_go) begin
            if (cmd.selected) begin
                st_d.hi     = addr[ADDR_W-1:CNT_W];
                st_d.cnt    = addr[CNT_W-1:0];
                st_d.active = 1'b1;
                // Controller start writes in the same clock; processor start waits.
                if (cmd.ctl_go && (|wr_lanes)) begin
                    mem_we     = wr_lanes;
                    mem_waddr  = addr;
                    st_d.fresh = 1'b0;
                end
            end else begin
                st_d.active = 1'b0;
                st_d.fresh  = 1'b1;
            end
        end else if (st_q.active) begin
            if (|wr_lanes) begin
                mem_we     = wr_lanes;
                st_d.fresh = 1'b0;
            end else begin
                st_d.rvalid = 1'b1;
                st_d.mask   = st_q.fresh;
                st_d.rdata  = mem_rword;
                st_d.fresh  = 1'b0;
            end
            if (!burst_adv_n) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.rdata;
    assign rd_valid = st_q.rvalid;
    assign rd_drive = st_q.rvalid && !st_q.mask && !out_en_n;
endmodule

// File: rtl/sbfe_checker.sv
module sbfe_checker
    import sbfe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_strobe_n,
    input logic              ctl_strobe_n,
    input logic              burst_adv_n,
    input logic              sel_a_n,
    input logic              sel_b,
    input logic              sel_c_n,
    input logic              all_wr_n,
    input logic              lane_wr_en_n,
    input logic [LANES-1:0]  lane_sel_n,
    input logic              out_en_n,
    input logic [WORD_W-1:0] rd_data,
    input logic              rd_valid,
    input logic              rd_drive
);
    logic strobe_go, sel_ok, desel, start_sel, wr_any;

    assign strobe_go = (!cpu_strobe_n && !sel_a_n) || !ctl_strobe_n;
    assign sel_ok    = !sel_a_n && sel_b && !sel_c_n;
    assign desel     = strobe_go && !sel_ok;
    assign start_sel = strobe_go && sel_ok;
    assign wr_any    = !all_wr_n || (!lane_wr_en_n && !(&lane_sel_n));

    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        desel |=> !rd_valid);

    a_r10_start_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        start_sel |=> !rd_valid);

    a_r6_hold_repeats: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !strobe_go && !wr_any && burst_adv_n && $past(burst_adv_n))
        |=> (rd_valid && $stable(rd_data)));

    a_r11_drive_gated: assert property (@(posedge clk) disable iff (!rst_n)
        rd_drive |-> (rd_valid && !out_en_n));

    a_r11_first_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
        desel ##1 (start_sel && !wr_any) ##1 (!strobe_go && !wr_any) |=> !rd_drive);
endmodule

bind burst_sram_ctl sbfe_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .burst_adv_n  (burst_adv_n),
    .sel_a_n      (sel_a_n),
    .sel_b        (sel_b),
    .sel_c_n      (sel_c_n),
    .all_wr_n     (all_wr_n),
    .lane_wr_en_n (lane_wr_en_n),
    .lane_sel_n   (lane_sel_n),
    .out_en_n     (out_en_n),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .rd_drive     (rd_drive)
);

// File: tb/burst_sram_ctl_tb.sv
`timescale 1ns/1ps
module burst_sram_ctl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  addr;
    logic        cpu_strobe_n, ctl_strobe_n, burst_adv_n;
    logic        sel_a_n, sel_b, sel_c_n;
    logic        all_wr_n, lane_wr_en_n;
    logic [1:0]  lane_sel_n;
    logic [17:0] wdata;
    logic        out_en_n;
    logic [17:0] rd_data;
    logic        rd_valid, rd_drive;

    int checks = 0;
    int failures = 0;
    bit mon_on = 1'b0;
    string idle_tag = "R1";

    typedef struct {
        logic [17:0] data;
        bit          unmask;
        string       tag;
    } exp_t;
    exp_t sbq[$];

    always #2.5 clk = ~clk;

    burst_sram_ctl #(.ADDR_W(10)) u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cpu_strobe_n(cpu_strobe_n), .ctl_strobe_n(ctl_strobe_n),
        .burst_adv_n(burst_adv_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .sel_c_n(sel_c_n), .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
        .lane_sel_n(lane_sel_n), .wdata(wdata), .out_en_n(out_en_n),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_drive(rd_drive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic set_idle();
        cpu_strobe_n = 1'b1; ctl_strobe_n = 1'b1; burst_adv_n = 1'b1;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        all_wr_n = 1'b1; lane_wr_en_n = 1'b1; lane_sel_n = 2'b11;
        wdata = '0; out_en_n = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic tick_rd(input logic [17:0] d, input bit unmask, input string tag);
        @(posedge clk); #1;
        sbq.push_back('{data: d, unmask: unmask, tag: tag});
    endtask

    // Monitor: one expected read per queued item, no read otherwise.
    always @(negedge clk) begin
        exp_t e;
        if (mon_on) begin
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                chk(rd_valid == 1'b1, e.tag, "rd_valid", 32'(rd_valid), 32'd1);
                chk(rd_data == e.data, e.tag, "rd_data", 32'(rd_data), 32'(e.data));
                chk(rd_drive == (e.unmask && !out_en_n), e.tag, "rd_drive",
                    32'(rd_drive), 32'(e.unmask && !out_en_n));
            end else begin
                chk(rd_valid == 1'b0, idle_tag, "unexpected read", 32'(rd_valid), 32'd0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [17:0] v, dv [4];
        addr = '0;
        set_idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1", "reset rd_valid", 32'(rd_valid), 32'd0);
        chk(rd_drive == 1'b0, "R1", "reset rd_drive", 32'(rd_drive), 32'd0);
        mon_on = 1'b1;
        tick();                                  // R1: no strobe, no read

        // R9/R7: controller start writes in the same clock
        addr = 10'h040; ctl_strobe_n = 1'b0; all_wr_n = 1'b0; wdata = 18'h12345;
        tick(); set_idle();
        // R2: deselect through sel_b
        idle_tag = "R2"; ctl_strobe_n = 1'b0; sel_b = 1'b0;
        tick(); set_idle();
        tick();
        idle_tag = "R10"; addr = 10'h040; ctl_strobe_n = 1'b0;
        tick(); set_idle();
        tick_rd(18'h12345, 1'b0, "R11 first read after deselect masked, R9 ctl write");
        tick_rd(18'h12345, 1'b1, "R6 hold");

        // R9: processor start ignores write inputs; writes on the next clock
        addr = 10'h081; cpu_strobe_n = 1'b0; all_wr_n = 1'b0; wdata = 18'h3AAAA;
        tick(); set_idle();
        all_wr_n = 1'b0; wdata = 18'h05555;
        tick(); set_idle();
        tick_rd(18'h05555, 1'b1, "R9 cpu write next clock");

        // R8: lane writes
        lane_wr_en_n = 1'b0; lane_sel_n = 2'b10; wdata = 18'h3FFFF;
        tick(); set_idle();
        v = {18'h05555 >> 9, 9'h1FF};
        v = {v[17:9], 9'h1FF};
        tick_rd(v, 1'b1, "R8 lane0 only");
        lane_wr_en_n = 1'b1; lane_sel_n = 2'b00; wdata = 18'h0;
        tick_rd(v, 1'b1, "R8 enable off no write");
        set_idle();
        lane_wr_en_n = 1'b0; lane_sel_n = 2'b01; wdata = 18'h0;
        tick(); set_idle();
        v = {9'h000, v[8:0]};
        tick_rd(v, 1'b1, "R8 lane1 only");
        all_wr_n = 1'b0; lane_wr_en_n = 1'b1; lane_sel_n = 2'b11; wdata = 18'h2BCDE;
        tick(); set_idle();
        tick_rd(18'h2BCDE, 1'b1, "R7 global write");

        // R5: burst wrap
        for (int i = 0; i < 4; i++) begin
            dv[i] = 18'h10000 | 18'(i * 18'h111);
            addr = 10'h100 + 10'(i); ctl_strobe_n = 1'b0; all_wr_n = 1'b0; wdata = dv[i];
            tick(); set_idle();
        end
        addr = 10'h102; ctl_strobe_n = 1'b0;
        tick(); set_idle();
        burst_adv_n = 1'b0;
        tick_rd(dv[2], 1'b1, "R5 beat0");
        tick_rd(dv[3], 1'b1, "R5 beat1");
        tick_rd(dv[0], 1'b1, "R5 wrap keeps upper bits");
        tick_rd(dv[1], 1'b1, "R5 beat3");
        burst_adv_n = 1'b1;
        tick_rd(dv[2], 1'b1, "R6 adv high holds");
        out_en_n = 1'b1;
        tick_rd(dv[2], 1'b1, "R11 out_en high");
        out_en_n = 1'b0;

        // R4: processor strobe disregarded with sel_a_n high
        cpu_strobe_n = 1'b0; sel_a_n = 1'b1; addr = 10'h200;
        tick_rd(dv[2], 1'b1, "R4 cpu strobe ignored");
        set_idle();
        idle_tag = "R4"; ctl_strobe_n = 1'b0; sel_a_n = 1'b1; addr = 10'h200;
        tick(); set_idle();
        tick();
        idle_tag = "R10"; addr = 10'h040; ctl_strobe_n = 1'b0;
        tick(); set_idle();
        tick_rd(18'h12345, 1'b0, "R11 masked after ctl deselect");
        idle_tag = "R2"; cpu_strobe_n = 1'b0; sel_c_n = 1'b1; addr = 10'h040;
        tick(); set_idle();
        tick();

        // R3: both strobes, processor wins, no start write
        idle_tag = "R3"; cpu_strobe_n = 1'b0; ctl_strobe_n = 1'b0; addr = 10'h040;
        all_wr_n = 1'b0; wdata = 18'h00F0F;
        tick(); set_idle();
        tick_rd(18'h12345, 1'b0, "R3 processor priority");
        tick_rd(18'h12345, 1'b1, "R3 hold");

        idle_tag = "R2"; ctl_strobe_n = 1'b0; sel_b = 1'b0;
        tick(); set_idle();
        tick();
        @(negedge clk);
        #1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule